// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block is the per-channel list walker that sits beside a DMA data mover. Software builds a table of 8-byte descriptors in memory, writes the table's start address into a byte-wide pointer window, and then sets the run bit in the command byte. The walker fetches one descriptor at a time over a simple memory-read handshake. It presents the buffer address and byte count of the current block to the data mover. When the data mover reports that the block has been consumed, the walker moves on to the next descriptor.

Each descriptor holds two little-endian 32-bit words. The buffer address comes first, at the lower address. The count word follows; its bit 31 marks the last descriptor in the table. After the last block has been consumed, the walker can raise an interrupt. A further block-consumed pulse after that point is flagged as an overrun. The walker does not move any data itself.

Top module: `sgd_engine`

## Requirements
- R1: The table pointer is written one byte at a time at register offsets 4 (bits 7:0) to 7 (bits 31:24), and its two low bits are always held at zero. Reading offset 4 returns the byte last written there, low bits included. Reading offsets 5 to 7 returns pointer bits 15:8, 23:16 and 31:24.
- R2: Writing the command byte (offset 0) so that its bit 0 goes from 0 to 1 starts the walker. The working pointer is loaded from the table pointer, status bit 0 (active) is set, and the irq output is cleared.
- R3: Each descriptor fetch makes exactly two memory reads, first at the working pointer and then at the working pointer plus 4. The request address holds steady until mem_ack. busy is high from the cycle after the start write (or after the block-consumed pulse) until the cycle after the second acknowledge.
- R4: cur_count equals count-word AND 0xFFFE, except that a result of zero gives 65536. Count-word bit 31 is the end-of-table flag, and it is shown in status bit 7.
- R5: When word_mode is high while the address word arrives, bit 0 of cur_addr is forced to 0. Otherwise the fetched address is kept unchanged.
- R6: A blk_done pulse on a block whose end-of-table flag is clear starts the fetch of the next descriptor, at the previous working pointer plus 8.
- R7: A blk_done pulse on the end-of-table block sets irq, one cycle later, only if command bits 7:6 equal 01. irq then stays high until the next start.
- R8: A blk_done pulse that arrives after the end-of-table block has finished sets status bit 6 (overrun) and fetches nothing. The overrun bit is cleared by the next start.
- R9: Writing the command byte so that its bit 0 goes from 1 to 0 stops the walker at once, even in the middle of a fetch. Status bits 0 and 7 are cleared, and no further memory request is made.
- R10: Status byte (offset 1): bit 5 is set when command bits 7:6 equal 01, bit 3 is set when the table pointer is non-zero, and bit 2 is set when cur_addr is non-zero. Bits 4 and 1 read as zero.
- R11: blk_done has no effect while a fetch is in progress or while the walker is stopped.
- R12: Writing the command byte with bit 0 set while bit 0 is already set starts no new fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset: 0 command, 1 status, 4..7 pointer bytes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| word_mode | input | 1 | Channel moves 16-bit words; buffer address is aligned to 2 |
| mem_req | output | 1 | Descriptor read request, held until acknowledged |
| mem_addr | output | 32 | Descriptor word address |
| mem_ack | input | 1 | Read acknowledge, with data valid |
| mem_rdata | input | 32 | Read data |
| blk_done | input | 1 | One-cycle pulse: current block fully consumed |
| cur_addr | output | 32 | Current block buffer address |
| cur_count | output | 17 | Current block byte count (1..65536) |
| busy | output | 1 | Descriptor fetch in progress; block values not valid |
| irq | output | 1 | End-of-table interrupt, level |

## Verification
All register writes and blk_done pulses take effect at the next rising edge. The bench drives them on a falling edge and samples one falling edge later. busy and irq are therefore due at the first falling edge after the stimulus. A full fetch ends four rising edges later, because the bench memory answers each request one cycle after it is raised. Rather than counting those cycles, the bench waits for busy to fall and then compares cur_addr, cur_count and status. Each memory handshake is matched against a queue of expected descriptor addresses, so an extra or missing fetch shows up as a mismatch or as a non-empty queue at the end.

// File: rtl/sgd_pkg.sv
`timescale 1ns/1ps
package sgd_pkg;

    localparam int WORD_W    = 32;
    localparam int CNT_W     = 17;
    localparam int RA_W      = 3;
    localparam int PTR_BYTES = WORD_W / 8;
    localparam int DESC_STEP = 2 * PTR_BYTES;

    localparam logic [RA_W-1:0] RA_CMD  = 3'd0;
    localparam logic [RA_W-1:0] RA_STAT = 3'd1;

    localparam logic [1:0] IRQ_MODE = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GET_ADDR,
        ST_GET_CNT,
        ST_READY,
        ST_END
    } walk_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [CNT_W-1:0]  count;
        logic              eot;
    } desc_t;

    // Count field keeps even lengths only; zero encodes the full 64 KiB block
    function automatic logic [CNT_W-1:0] decode_count(input logic [WORD_W-1:0] w);
        logic [15:0] c;
        c = w[15:0] & 16'hFFFE;
        return (c == 16'd0) ? CNT_W'(17'h10000) : {1'b0, c};
    endfunction

    function automatic logic [WORD_W-1:0] align_buf(input logic [WORD_W-1:0] a,
                                                    input logic wide);
        return wide ? {a[WORD_W-1:1], 1'b0} : a;
    endfunction

endpackage

// File: rtl/sgd_regs.sv
`timescale 1ns/1ps
module sgd_regs
    import sgd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [RA_W-1:0]   addr,
    input  logic [7:0]        wdata,
    input  logic [7:0]        stat_byte,
    output logic [7:0]        rdata,
    output logic [7:0]        cmd,
    output logic [WORD_W-1:0] tbl_ptr,
    output logic              start_p,
    output logic              stop_p
);

    logic [7:0]        cmd_q;
    logic [7:0]        raw0_q;
    logic [WORD_W-1:0] ptr_q;
    logic              cmd_wr;

    assign cmd_wr  = wr_en && (addr == RA_CMD);
    assign start_p = cmd_wr &&  wdata[0] && !cmd_q[0];
    assign stop_p  = cmd_wr && !wdata[0] &&  cmd_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            raw0_q <= '0;
            ptr_q  <= '0;
        end else if (wr_en) begin
            if (addr == RA_CMD)
                cmd_q <= wdata;
            for (int b = 0; b < PTR_BYTES; b++) begin
                if (addr[2] && (addr[1:0] == 2'(b))) begin
                    if (b == 0) begin
                        ptr_q[7:0] <= wdata & 8'hFC;
                        raw0_q     <= wdata;
                    end else begin
                        ptr_q[8*b +: 8] <= wdata;
                    end
                end
            end
        end
    end

    always_comb begin
        case (addr)
            RA_CMD:  rdata = cmd_q;
            RA_STAT: rdata = stat_byte;
            3'd4:    rdata = raw0_q;
            3'd5:    rdata = ptr_q[15:8];
            3'd6:    rdata = ptr_q[23:16];
            3'd7:    rdata = ptr_q[31:24];
            default: rdata = 8'hFF;
        endcase
    end

    assign cmd     = cmd_q;
    assign tbl_ptr = ptr_q;

endmodule

// File: rtl/sgd_walker.sv
`timescale 1ns/1ps
module sgd_walker
    import sgd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic [WORD_W-1:0] tbl_ptr,
    input  logic              word_mode,
    input  logic              irq_en,
    input  logic              blk_done,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    output desc_t             cur,
    output logic              active,
    output logic              irq,
    output logic              overrun
);

    walk_state_t       state_q;
    logic [WORD_W-1:0] wptr_q;
    desc_t             desc_q;
    logic              active_q;
    logic              irq_q;
    logic              ovr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            wptr_q   <= '0;
            desc_q   <= '0;
            active_q <= 1'b0;
            irq_q    <= 1'b0;
            ovr_q    <= 1'b0;
        end else if (stop_p) begin
            state_q    <= ST_IDLE;
            active_q   <= 1'b0;
            desc_q.eot <= 1'b0;
        end else if (start_p) begin
            state_q    <= ST_GET_ADDR;
            wptr_q     <= tbl_ptr;
            active_q   <= 1'b1;
            irq_q      <= 1'b0;
            ovr_q      <= 1'b0;
            desc_q.eot <= 1'b0;
        end else begin
            case (state_q)
                ST_GET_ADDR: if (mem_ack) begin
                    desc_q.addr <= align_buf(mem_rdata, word_mode);
                    state_q     <= ST_GET_CNT;
                end
                ST_GET_CNT: if (mem_ack) begin
                    desc_q.count <= decode_count(mem_rdata);
                    desc_q.eot   <= mem_rdata[WORD_W-1];
                    wptr_q       <= wptr_q + WORD_W'(DESC_STEP);
                    state_q      <= ST_READY;
                end
                ST_READY: if (blk_done) begin
                    if (desc_q.eot) begin
                        state_q <= ST_END;
                        if (irq_en)
                            irq_q <= 1'b1;
                    end else begin
                        state_q <= ST_GET_ADDR;
                    end
                end
                ST_END: if (blk_done)
                    ovr_q <= 1'b1;
                default: ;
            endcase
        end
    end

    assign mem_req  = (state_q == ST_GET_ADDR) || (state_q == ST_GET_CNT);
    assign mem_addr = (state_q == ST_GET_CNT) ? wptr_q + WORD_W'(PTR_BYTES) : wptr_q;
    assign cur      = desc_q;
    assign active   = active_q;
    assign irq      = irq_q;
    assign overrun  = ovr_q;

endmodule

// File: rtl/sgd_status.sv
`timescale 1ns/1ps
module sgd_status
    import sgd_pkg::*;
(
    input  logic              active,
    input  logic              eot,
    input  logic              overrun,
    input  logic [1:0]        irq_mode,
    input  logic [WORD_W-1:0] tbl_ptr,
    input  logic [WORD_W-1:0] buf_addr,
    output logic [7:0]        stat_byte
);

    always_comb begin
        stat_byte    = '0;
        stat_byte[0] = active;
        stat_byte[2] = (buf_addr != '0);
        stat_byte[3] = (tbl_ptr != '0);
        stat_byte[5] = (irq_mode == IRQ_MODE);
        stat_byte[6] = overrun;
        stat_byte[7] = eot;
    end

endmodule

// File: rtl/sgd_engine.sv
`timescale 1ns/1ps
module sgd_engine
    import sgd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              word_mode,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              blk_done,
    output logic [WORD_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_count,
    output logic              busy,
    output logic              irq
);

    logic [7:0]        cmd_w;
    logic [7:0]        stat_w;
    logic [WORD_W-1:0] ptr_w;
    logic              start_w;
    logic              stop_w;
    logic              active_w;
    logic              ovr_w;
    desc_t             cur_w;

    sgd_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .stat_byte (stat_w),
        .rdata     (reg_rdata),
        .cmd       (cmd_w),
        .tbl_ptr   (ptr_w),
        .start_p   (start_w),
        .stop_p    (stop_w)
    );

    sgd_walker u_walk (
        .clk       (clk),
        .rst       (rst),
        .start_p   (start_w),
        .stop_p    (stop_w),
        .tbl_ptr   (ptr_w),
        .word_mode (word_mode),
        .irq_en    (cmd_w[7:6] == IRQ_MODE),
        .blk_done  (blk_done),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .cur       (cur_w),
        .active    (active_w),
        .irq       (irq),
        .overrun   (ovr_w)
    );

    sgd_status u_stat (
        .active    (active_w),
        .eot       (cur_w.eot),
        .overrun   (ovr_w),
        .irq_mode  (cmd_w[7:6]),
        .tbl_ptr   (ptr_w),
        .buf_addr  (cur_w.addr),
        .stat_byte (stat_w)
    );

    assign cur_addr  = cur_w.addr;
    assign cur_count = cur_w.count;
    assign busy      = mem_req;

endmodule

// File: rtl/sgd_engine_chk.sv
`timescale 1ns/1ps
module sgd_engine_chk
    import sgd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [RA_W-1:0]   reg_addr,
    input logic [7:0]        reg_wdata,
    input logic              mem_req,
    input logic [WORD_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              blk_done,
    input logic [CNT_W-1:0]  cur_count,
    input logic              irq
);

    logic stop_wr;
    logic run_wr;
    assign stop_wr = reg_wr && (reg_addr == RA_CMD) && !reg_wdata[0];
    assign run_wr  = reg_wr && (reg_addr == RA_CMD) &&  reg_wdata[0];

    AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));                       // R1

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !stop_wr) |=> (mem_req && $stable(mem_addr))); // R3

    AST_COUNT_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (cur_count[0] == 1'b0) && (cur_count <= CNT_W'(17'h10000)));  // R4

    AST_IRQ_FROM_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(blk_done));                             // R7

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq && !run_wr) |=> irq);                                   // R7

    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        stop_wr |=> !mem_req);                                       // R9

endmodule

bind sgd_engine sgd_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .blk_done  (blk_done),
    .cur_count (cur_count),
    .irq       (irq)
);

// File: tb/sgd_engine_bench.sv
`timescale 1ns/1ps
module sgd_engine_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [2:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        word_mode;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic        blk_done;
    logic [31:0] cur_addr;
    logic [16:0] cur_count;
    logic        busy;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] mem [16];
    logic [31:0] exp_q [$];

    always #5 clk = ~clk;

    sgd_engine u_sgd_engine (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .word_mode(word_mode),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .blk_done(blk_done), .cur_addr(cur_addr),
        .cur_count(cur_count), .busy(busy), .irq(irq)
    );

    // Memory responder: one-cycle latency, ack for one cycle per request
    always @(posedge clk) begin
        if (rst) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack   <= mem_req && !mem_ack;
            mem_rdata <= mem[mem_addr[5:2]];
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Monitor: every accepted descriptor read is compared with the scoreboard
    always @(negedge clk) begin
        if (!rst && mem_req && mem_ack) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R3/R6/R12: unexpected fetch at %0h expected none", mem_addr);
            end else begin
                check("R3 fetch address", mem_addr, exp_q.pop_front());
            end
        end
    end

    task automatic expect_fetch(input logic [31:0] p);
        exp_q.push_back(p);
        exp_q.push_back(p + 32'd4);
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        blk_done = 1'b1;
        @(negedge clk);
        blk_done = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 50 && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        for (int i = 0; i < 16; i++) mem[i] = '0;
        mem[4] = 32'h0000_1235; mem[5] = 32'h0000_0101;
        mem[6] = 32'h0000_2000; mem[7] = 32'h8000_0000;
        rst = 1'b1; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        word_mode = 1'b1; blk_done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        reg_read(3'd1, rd);
        check("R10 reset status", rd, 8'h00);
        check("R3 reset busy", busy, 0);
        check("R7 reset irq", irq, 0);

        // R1 pointer bytes
        reg_write(3'd4, 8'h13); reg_write(3'd5, 8'h57);
        reg_write(3'd6, 8'h9B); reg_write(3'd7, 8'hDF);
        reg_read(3'd4, rd); check("R1 raw byte 0", rd, 8'h13);
        reg_read(3'd5, rd); check("R1 byte 1", rd, 8'h57);
        reg_read(3'd6, rd); check("R1 byte 2", rd, 8'h9B);
        reg_read(3'd7, rd); check("R1 byte 3", rd, 8'hDF);
        reg_read(3'd1, rd); check("R10 pointer nonzero bit", rd, 8'h08);
        reg_write(3'd5, 8'h00); reg_write(3'd6, 8'h00); reg_write(3'd7, 8'h00);

        // R2 start with irq mode 01; pointer masked to 0x10 (R1)
        expect_fetch(32'h10);
        reg_write(3'd0, 8'h41);
        check("R3 busy after start", busy, 1);
        wait_idle();
        check("R5 word aligned address", cur_addr, 32'h1234);
        check("R4 masked count", cur_count, 17'h100);
        reg_read(3'd1, rd); check("R2 R10 status active", rd, 8'h2D);

        // R12 rewrite run bit: no fetch
        reg_write(3'd0, 8'h41);
        check("R12 no refetch busy", busy, 0);
        repeat (4) @(negedge clk);
        check("R12 address unchanged", cur_addr, 32'h1234);

        // R6 next descriptor, R11 pulse during fetch ignored
        expect_fetch(32'h18);
        pulse_done();
        pulse_done();
        wait_idle();
        check("R6 next address", cur_addr, 32'h2000);
        check("R4 zero count is 65536", cur_count, 17'h10000);
        check("R11 irq not raised by pulse in fetch", irq, 0);
        reg_read(3'd1, rd); check("R4 eot status", rd, 8'hAD);

        // R7 terminal count
        pulse_done();
        check("R7 irq raised", irq, 1);
        // R8 overrun
        pulse_done();
        reg_read(3'd1, rd); check("R8 overrun status", rd, 8'hED);
        check("R8 no fetch", busy, 0);

        // R9 stop
        reg_write(3'd0, 8'h40);
        reg_read(3'd1, rd); check("R9 stop clears active and eot", rd, 8'h6C);
        pulse_done();
        check("R11 pulse while stopped", busy, 0);

        // R2 restart, mode 00, byte mode
        word_mode = 1'b0;
        expect_fetch(32'h10);
        reg_write(3'd0, 8'h01);
        check("R2 irq cleared at start", irq, 0);
        wait_idle();
        check("R5 byte mode address", cur_addr, 32'h1235);
        reg_read(3'd1, rd); check("R2 R8 restart status", rd, 8'h0D);
        expect_fetch(32'h18);
        pulse_done();
        wait_idle();
        pulse_done();
        check("R7 no irq without mode 01", irq, 0);
        reg_read(3'd1, rd); check("R7 end status", rd, 8'h8D);

        // R9 stop in the middle of a fetch
        reg_write(3'd0, 8'h00);
        exp_q.push_back(32'h10);
        reg_write(3'd0, 8'h01);
        reg_write(3'd0, 8'h00);
        check("R9 busy dropped", busy, 0);
        repeat (4) @(negedge clk);
        reg_read(3'd1, rd); check("R9 inactive after abort", rd[0], 0);
        check("R3 scoreboard drained", exp_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule